// File: doc/BRIEF.md
# E1 Timeslot Strobe and Channel Blocking Generator

This block produces per-timeslot timing strobes for one direction of a 2.048 Mbit/s E1 framer. It tracks the bit position (eight bits, most significant first) and the timeslot position (32 timeslots, timeslot 0 first) of the serial stream. It drives a channel clock that is high for one bit period in every timeslot, during its last bit (the LSB). It also drives a channel-blocking level that software sets per timeslot through a 32-bit mask.

The block runs on one fabric clock. Each of the two possible timing domains, line side and system side, supplies a one-cycle bit-advance strobe and a frame-sync flag. A domain-select input chooses the pair that drives the counters, matching the rule that the strobes follow the line clock when the elastic store is bypassed and the system clock when it is in use. Both outputs change only on a fabric-clock rising edge that carries an accepted bit advance, so they are steady for the whole bit period and are safe to sample on the falling edge of the bit clock. The mask is loaded one byte at a time through a small write port.

Top module: `e1cb_strobe_gen`

## Requirements
- R1: During and right after reset, `chan_clk` and `chan_blk` are 0, every mask bit is 0, and the position is the last bit of timeslot 31, so the first advance without sync lands on bit 1 of timeslot 0.
- R2: On each accepted advance without sync, the position moves on by one bit. It wraps from bit 8 to bit 1 of the next timeslot, and from timeslot 31 bit 8 to timeslot 0 bit 1. `chan_clk` is 1 exactly while the position is bit 8 of a timeslot, which is one bit period in every eight.
- R3: An accepted advance with the frame-sync flag set puts the position at timeslot 0 bit 1, whatever the position was before.
- R4: `chan_blk` equals mask bit n for all eight bit periods of timeslot n.
- R5: A write with `mask_wr_en` = 1 stores `mask_wr_data` into the byte chosen by `mask_wr_idx`. Byte k holds timeslots 8k to 8k+7, and data bit j sets the level for timeslot 8k+j. The new level appears on `chan_blk` from the next accepted advance onward.
- R6: With `dom_sel` = 0 only `line_bit_en` and `line_fsync` are used; with `dom_sel` = 1 only `sys_bit_en` and `sys_fsync` are used. Strobes of the other domain have no effect. A change of `dom_sel` keeps the current position.
- R7: On a clock edge without an accepted advance, `chan_clk` and `chan_blk` keep their values, even when the mask is written.
- R8: A frame-sync flag without the bit-advance strobe of the same domain has no effect on the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_sel | input | 1 | 0 = line-side timing, 1 = system-side timing |
| line_bit_en | input | 1 | Line-side one-cycle bit-advance strobe |
| line_fsync | input | 1 | Line-side frame sync, marks bit 1 of timeslot 0 |
| sys_bit_en | input | 1 | System-side one-cycle bit-advance strobe |
| sys_fsync | input | 1 | System-side frame sync, marks bit 1 of timeslot 0 |
| mask_wr_en | input | 1 | Mask byte write enable |
| mask_wr_idx | input | 2 | Mask byte index (timeslots 8k to 8k+7) |
| mask_wr_data | input | 8 | Mask byte; bit j is timeslot 8k+j |
| chan_clk | output | 1 | Channel clock, high during bit 8 of each timeslot |
| chan_blk | output | 1 | Channel-blocking level of the current timeslot |

## Verification
The bench builds the block with its default parameters: 32 timeslots of 8 bits and an 8-bit write port, which gives four mask bytes. With these values a full frame is 256 bit periods, so several complete frames, the wrap from timeslot 31 to 0, and every mask byte lane fit into a short run. The bench also varies the spacing of the bit strobes from every fabric cycle to every fourth cycle. This exposes both the back-to-back advance path and the hold between advances, while syncs land at arbitrary positions and the unused domain is driven with noise.

// File: rtl/e1cb_pkg.sv
// Package: shared constants and types for the E1 timeslot strobe generator.
// Assumes one fabric clock; the bit rate reaches the block as enable strobes.
package e1cb_pkg;
    localparam int unsigned E1_SLOTS  = 32;
    localparam int unsigned E1_BITS   = 8;
    localparam int unsigned E1_BYTE_W = 8;

    // Timing domain that drives the position counters.
    typedef enum logic {
        DOM_LINE = 1'b0,
        DOM_SYS  = 1'b1
    } e1cb_dom_e;
endpackage

// File: rtl/e1cb_src_sel.sv
// Module: e1cb_src_sel
// Picks the bit-advance strobe and frame-sync flag of the selected domain.
// Assumes the strobes are already synchronous to clk and one cycle wide.
module e1cb_src_sel
    import e1cb_pkg::*;
(
    input  logic dom_sel,
    input  logic line_bit_en,
    input  logic line_fsync,
    input  logic sys_bit_en,
    input  logic sys_fsync,
    output logic adv,
    output logic sync_ld
);
    e1cb_dom_e dom;

    // Decode the select into the domain type.
    always_comb dom = e1cb_dom_e'(dom_sel);

    // Route the chosen pair; sync only counts together with an advance.
    always_comb begin
        if (dom == DOM_SYS) begin
            adv     = sys_bit_en;
            sync_ld = sys_bit_en & sys_fsync;
        end else begin
            adv     = line_bit_en;
            sync_ld = line_bit_en & line_fsync;
        end
    end
endmodule

// File: rtl/e1cb_pos_cnt.sv
// Module: e1cb_pos_cnt
// Tracks bit (0..BITS-1) and timeslot (0..SLOTS-1) of the current bit period.
// Offers the next position combinationally so the top can register outputs
// on the same edge. Reset leaves the position on the last bit of the last
// slot, so a free-running start begins at slot 0 bit 0.
module e1cb_pos_cnt #(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned BITS  = 8,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              sync_ld,
    output logic [SLOT_W-1:0] slot_q,
    output logic [BIT_W-1:0]  bit_q,
    output logic [SLOT_W-1:0] slot_nx,
    output logic [BIT_W-1:0]  bit_nx
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS - 1);

    // Next position: sync load, wrap, or step.
    always_comb begin
        slot_nx = slot_q;
        bit_nx  = bit_q;
        if (sync_ld) begin
            slot_nx = '0;
            bit_nx  = '0;
        end else if (adv) begin
            if (bit_q == BIT_LAST) begin
                bit_nx  = '0;
                slot_nx = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
            end else begin
                bit_nx = bit_q + 1'b1;
            end
        end
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_LAST;
            bit_q  <= BIT_LAST;
        end else begin
            slot_q <= slot_nx;
            bit_q  <= bit_nx;
        end
    end

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !sync_ld && bit_q == BIT_LAST && slot_q == SLOT_LAST
        |=> slot_q == '0 && bit_q == '0);

    // R2
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !sync_ld && bit_q != BIT_LAST
        |=> bit_q == $past(bit_q) + 1'b1 && slot_q == $past(slot_q));

    // R3
    sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ld |=> slot_q == '0 && bit_q == '0);

    // R8
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(slot_q) && $stable(bit_q));
endmodule

// File: rtl/e1cb_mask_reg.sv
// Module: e1cb_mask_reg
// Per-timeslot blocking mask, written one byte at a time. Byte k covers
// slots k*BYTE_W .. k*BYTE_W+BYTE_W-1, LSB first. Assumes SLOTS is a
// multiple of BYTE_W.
module e1cb_mask_reg #(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned N_BYTES = SLOTS / BYTE_W,
    localparam int unsigned IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [SLOTS-1:0]  mask
);
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        // Load this byte lane when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                byte_q <= wr_data;
            end
        end

        assign mask[k*BYTE_W +: BYTE_W] = byte_q;

        // R5
        byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_idx == IDX_W'(k) |=> byte_q == $past(wr_data));
    end
endmodule

// File: rtl/e1cb_strobe_gen.sv
// Module: e1cb_strobe_gen (top)
// Generates the per-timeslot channel clock (high during the last bit of
// every slot) and the per-slot blocking level for one E1 direction.
// Assumes bit strobes are synchronous one-cycle enables on clk; outputs are
// registered and only move on an accepted advance, so they are steady for a
// whole bit period.
module e1cb_strobe_gen
    import e1cb_pkg::*;
#(
    parameter int unsigned SLOTS  = E1_SLOTS,
    parameter int unsigned BITS   = E1_BITS,
    parameter int unsigned BYTE_W = E1_BYTE_W,
    localparam int unsigned SLOT_W  = $clog2(SLOTS),
    localparam int unsigned BIT_W   = $clog2(BITS),
    localparam int unsigned N_BYTES = SLOTS / BYTE_W,
    localparam int unsigned IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dom_sel,
    input  logic              line_bit_en,
    input  logic              line_fsync,
    input  logic              sys_bit_en,
    input  logic              sys_fsync,
    input  logic              mask_wr_en,
    input  logic [IDX_W-1:0]  mask_wr_idx,
    input  logic [BYTE_W-1:0] mask_wr_data,
    output logic              chan_clk,
    output logic              chan_blk
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

    logic              adv;
    logic              sync_ld;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_nx;
    logic [BIT_W-1:0]  bit_nx;
    logic [SLOTS-1:0]  mask;

    e1cb_src_sel i_src_sel (
        .dom_sel     (dom_sel),
        .line_bit_en (line_bit_en),
        .line_fsync  (line_fsync),
        .sys_bit_en  (sys_bit_en),
        .sys_fsync   (sys_fsync),
        .adv         (adv),
        .sync_ld     (sync_ld)
    );

    e1cb_pos_cnt #(.SLOTS(SLOTS), .BITS(BITS)) i_pos_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .sync_ld (sync_ld),
        .slot_q  (slot_q),
        .bit_q   (bit_q),
        .slot_nx (slot_nx),
        .bit_nx  (bit_nx)
    );

    e1cb_mask_reg #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) i_mask_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_idx  (mask_wr_idx),
        .wr_data (mask_wr_data),
        .mask    (mask)
    );

    // Register both strobes from the position that starts with this advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_clk <= 1'b0;
            chan_blk <= 1'b0;
        end else if (adv) begin
            chan_clk <= (bit_nx == BIT_LAST);
            chan_blk <= mask[slot_nx];
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(chan_clk) && $stable(chan_blk));

    // R2
    clk_at_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> chan_clk == (bit_q == BIT_LAST));

    // R4
    blk_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !mask_wr_en |=> chan_blk == mask[slot_q]);
endmodule

// File: tb/test_e1cb_strobe_gen.sv
// Bench: behavioural position/mask model compared on every clock.
module test_e1cb_strobe_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dom_sel, line_bit_en, line_fsync, sys_bit_en, sys_fsync;
    logic       mask_wr_en;
    logic [1:0] mask_wr_idx;
    logic [7:0] mask_wr_data;
    logic       chan_clk, chan_blk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string tag = "R1";

    // Reference model state.
    int          m_slot, m_bit;
    bit          m_clk, m_blk;
    bit [31:0]   m_mask;
    bit          m_adv;

    always #5 clk = ~clk;

    e1cb_strobe_gen i_e1cb_strobe_gen (
        .clk(clk), .rst_n(rst_n), .dom_sel(dom_sel),
        .line_bit_en(line_bit_en), .line_fsync(line_fsync),
        .sys_bit_en(sys_bit_en), .sys_fsync(sys_fsync),
        .mask_wr_en(mask_wr_en), .mask_wr_idx(mask_wr_idx),
        .mask_wr_data(mask_wr_data),
        .chan_clk(chan_clk), .chan_blk(chan_blk)
    );

    // Model update on every rising edge.
    always @(posedge clk) begin
        bit en, sy;
        en = dom_sel ? sys_bit_en : line_bit_en;
        sy = dom_sel ? sys_fsync  : line_fsync;
        m_adv = 1'b0;
        if (!rst_n) begin
            m_slot = 31; m_bit = 7; m_clk = 0; m_blk = 0; m_mask = '0;
        end else begin
            if (en) begin
                m_adv = 1'b1;
                if (sy) begin
                    m_slot = 0; m_bit = 0;
                end else if (m_bit == 7) begin
                    m_bit = 0; m_slot = (m_slot + 1) % 32;
                end else begin
                    m_bit = m_bit + 1;
                end
                m_clk = (m_bit == 7);
                m_blk = m_mask[m_slot];
            end
            if (mask_wr_en) m_mask[mask_wr_idx*8 +: 8] = mask_wr_data;
        end
        cyc++;
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    logic prev_clk, prev_blk;

    // One clock: drive inputs, pass the edge, compare at the falling edge.
    task automatic tick(input logic le, input logic ls, input logic se, input logic ss);
        line_bit_en = le; line_fsync = ls; sys_bit_en = se; sys_fsync = ss;
        prev_clk = chan_clk; prev_blk = chan_blk;
        @(posedge clk);
        @(negedge clk);
        mask_wr_en = 1'b0;
        chk(tag, chan_clk, m_clk, "chan_clk");
        chk(tag, chan_blk, m_blk, "chan_blk");
        if (!m_adv && rst_n) begin
            // R7: no accepted advance, outputs hold
            chk("R7", chan_clk, prev_clk, "chan_clk hold");
            chk("R7", chan_blk, prev_blk, "chan_blk hold");
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        mask_wr_en = 1'b1; mask_wr_idx = idx; mask_wr_data = d;
    endtask

    // Run n bit periods on the selected domain with a given strobe spacing;
    // the other domain receives noise.
    task automatic run(input int nbits, input int gap, input int sync_at);
        for (int b = 0; b < nbits; b++) begin
            for (int g = 0; g < gap; g++) begin
                logic en, sy, nz;
                en = (g == gap - 1);
                sy = en && (b == sync_at);
                nz = ((b + g) % 3) == 0;
                if (dom_sel) tick(nz, nz, en, sy);
                else         tick(en, sy, nz, nz);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; dom_sel = 1'b0; mask_wr_en = 1'b0;
        mask_wr_idx = '0; mask_wr_data = '0;
        line_bit_en = 0; line_fsync = 0; sys_bit_en = 0; sys_fsync = 0;
        @(negedge clk);
        tag = "R1";
        tick(1, 0, 1, 0);
        tick(0, 0, 0, 0);
        chk("R1", chan_clk, 1'b0, "chan_clk in reset");
        chk("R1", chan_blk, 1'b0, "chan_blk in reset");
        rst_n = 1'b1;
        tick(0, 0, 0, 0);
        // R1: first free-running advance lands on slot 0 bit 1, mask zero
        tick(1, 0, 0, 0);
        chk("R1", chan_clk, 1'b0, "chan_clk first bit");
        chk("R1", chan_blk, 1'b0, "chan_blk zero mask");

        tag = "R2";
        run(300, 2, -1);

        tag = "R5";
        wr(2'd0, 8'h81); tick(0, 0, 0, 0);
        wr(2'd1, 8'h0F); tick(0, 0, 0, 0);
        wr(2'd2, 8'hC3); tick(0, 0, 0, 0);
        wr(2'd3, 8'hA5); tick(0, 0, 0, 0);
        tag = "R4";
        run(600, 3, -1);

        tag = "R3";
        run(100, 2, 37);
        run(300, 1, 5);

        tag = "R8";
        for (int i = 0; i < 40; i++) tick(i % 4 == 3, 1, 0, 0);

        tag = "R6";
        dom_sel = 1'b1;
        run(550, 4, 200);
        wr(2'd1, 8'h5A); tick(0, 0, 0, 0);
        dom_sel = 1'b0;
        run(300, 1, 260);

        tag = "R5";
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 7) wr(2'(i / 50), 8'(i * 37 + 11));
            tick(i % 2 == 1, 0, 1, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d, actual=running expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule